// File: doc/BRIEF.md
# Handshake Interval Timer Bank

This block keeps the byte-wide duration settings of a modem connection handshake. It also measures each of those intervals with a countdown timer. A free-running divider turns the system clock into three ticks, one for each time unit: a short tick (5/3 ms), a medium tick (53.3 ms) and a long tick (1 s). Each timer counts on the tick of its own unit.

A handshake controller writes and reads the settings through a plain address/data port. It starts a timer by giving its index together with a one-cycle start strobe. The timer copies its duration from the setting register, or from the register pair, that belongs to that index. Changes made to the settings afterwards do not disturb a count that is already running. Each timer shows a busy level and gives a one-cycle done pulse when it expires.

All pins are plain control and status signals, with no back-pressure. A write is always accepted in the cycle it is presented. A read returns data in the same cycle. A start is taken in the cycle its strobe is high.

Top module: `handshake_timer_bank`

## Requirements
- R1: After reset the settings read as follows. Address 0 (tone length, long units) reads 0x03. Address 1 (fallback tone length, short units) reads 0x5A. Address 2 (tone-to-transmit delay) reads 0x2D. Address 3 (receive tone length) reads 0x3C. Address 4 (scrambled-ones delay, medium units) reads 0x09. Addresses 5 and 6 (data delay low and high) read 0xCB and 0x08. Addresses 7 and 8 (fast scrambled-ones low and high) read 0x78 and 0x08. Addresses 9 to 15 always read 0x00, and writes to them are ignored. After reset all busy and done outputs are 0.
- R2: A write with `reg_wr` high updates the addressed setting at that clock edge. `reg_rdata` shows the addressed setting combinationally.
- R3: Ticks are counted from the first clock edge after reset is released; that edge is edge 0. The short tick is active at edge c when c mod SHORT_DIV = SHORT_DIV-1. The medium tick is active when c mod (SHORT_DIV·MID_DIV) = SHORT_DIV·MID_DIV-1. The long tick is active when c mod (SHORT_DIV·LONG_DIV) = SHORT_DIV·LONG_DIV-1.
- R4: Each timer index uses one setting and one unit. Index 1 uses address 2 in short units. Index 2 uses address 3 in short units. Index 3 uses address 4 in medium units. Index 4 uses the data-delay pair in short units. Index 5 uses the fast scrambled-ones pair in short units.
- R5: A pair forms a 16-bit duration: high × 256 + low.
- R6: Index 0 uses address 0 in long units. When address 0 holds zero, index 0 uses address 1 in short units instead.
- R7: A start with `tmr_sel`=i loads timer i at that edge. A tick at the same edge is not counted. Each later edge with the timer's tick counts once. The timer expires at its count number max(V,1), where V is the loaded value. Busy is high from the start edge until the expiry edge. Done is high for exactly the one cycle after the expiry edge.
- R8: A loaded value of zero expires on the first tick of its unit.
- R9: A start on a busy timer reloads it and produces no done for the count it abandons.
- R10: Writes made while a timer is running change neither its duration nor its unit. They take effect at the next start.
- R11: A start with `tmr_sel` of 6 or 7 changes no timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Setting write strobe |
| reg_addr | input | 4 | Setting address |
| reg_wdata | input | 8 | Setting write data |
| reg_rdata | output | 8 | Setting read data for `reg_addr` |
| tmr_start | input | 1 | Timer start strobe |
| tmr_sel | input | 3 | Index of the timer to start |
| tmr_busy | output | 6 | Per-timer running flag |
| tmr_done | output | 6 | Per-timer one-cycle expiry pulse |

## Verification
A count value captured wrongly, or a unit that is wrong or latched at the wrong time, shows up as a done pulse landing on the wrong tick. The error is therefore visible as soon as the expected expiry tick passes. It can take up to one unit period to appear, or a whole pair-weighted span for the long pairs. A divider that drifts moves every later expiry, so a bench that models tick positions from reset and compares busy and done on every cycle catches the drift on the first affected tick. A corrupted setting is visible on the read port in the cycle after the write. It also shows up at the next start that uses the setting.

// File: rtl/hitb_pkg.sv
package hitb_pkg;
  localparam int NUM_TIMERS = 6;
  localparam int NUM_REGS   = 9;
  localparam int ADDR_W     = 4;
  localparam int SEL_W      = $clog2(NUM_TIMERS + 2);
  localparam int CNT_W      = 16;

  typedef enum logic [1:0] {
    UNIT_SHORT = 2'd0,
    UNIT_MID   = 2'd1,
    UNIT_LONG  = 2'd2
  } unit_e;

  typedef struct packed {
    logic [CNT_W-1:0] val;
    unit_e            unit;
  } load_t;

  localparam int A_TONE_LONG = 0;
  localparam int A_TONE_ALT  = 1;
  localparam int A_TONE_GAP  = 2;
  localparam int A_RX_TONE   = 3;
  localparam int A_SCR_DLY   = 4;
  localparam int A_DDLY_LO   = 5;
  localparam int A_DDLY_HI   = 6;
  localparam int A_FSCR_LO   = 7;
  localparam int A_FSCR_HI   = 8;

  function automatic logic [7:0] reg_reset(int idx);
    case (idx)
      A_TONE_LONG: return 8'h03;
      A_TONE_ALT:  return 8'h5A;
      A_TONE_GAP:  return 8'h2D;
      A_RX_TONE:   return 8'h3C;
      A_SCR_DLY:   return 8'h09;
      A_DDLY_LO:   return 8'hCB;
      A_DDLY_HI:   return 8'h08;
      A_FSCR_LO:   return 8'h78;
      A_FSCR_HI:   return 8'h08;
      default:     return 8'h00;
    endcase
  endfunction

  function automatic load_t timer_load(int t, logic [NUM_REGS-1:0][7:0] r);
    load_t l;
    l.val  = '0;
    l.unit = UNIT_SHORT;
    case (t)
      0: begin
        if (r[A_TONE_LONG] != 8'h00) begin
          l.val  = {8'h00, r[A_TONE_LONG]};
          l.unit = UNIT_LONG;
        end else begin
          l.val  = {8'h00, r[A_TONE_ALT]};
          l.unit = UNIT_SHORT;
        end
      end
      1: l.val = {8'h00, r[A_TONE_GAP]};
      2: l.val = {8'h00, r[A_RX_TONE]};
      3: begin
        l.val  = {8'h00, r[A_SCR_DLY]};
        l.unit = UNIT_MID;
      end
      4: l.val = {r[A_DDLY_HI], r[A_DDLY_LO]};
      5: l.val = {r[A_FSCR_HI], r[A_FSCR_LO]};
      default: l.val = '0;
    endcase
    return l;
  endfunction
endpackage

// File: rtl/hitb_tick_gen.sv
module hitb_tick_gen #(
  parameter int SHORT_DIV = 8192,
  parameter int MID_DIV   = 32,
  parameter int LONG_DIV  = 600
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [3:0] ticks
);
  localparam int SW = $clog2(SHORT_DIV);
  localparam int MW = $clog2(MID_DIV);
  localparam int LW = $clog2(LONG_DIV);

  logic [SW-1:0] s_cnt;
  logic [MW-1:0] m_cnt;
  logic [LW-1:0] l_cnt;
  logic t_short, t_mid, t_long;

  assign t_short = (s_cnt == SW'(SHORT_DIV - 1));
  assign t_mid   = t_short && (m_cnt == MW'(MID_DIV - 1));
  assign t_long  = t_short && (l_cnt == LW'(LONG_DIV - 1));
  assign ticks   = {1'b0, t_long, t_mid, t_short};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cnt <= '0;
      m_cnt <= '0;
      l_cnt <= '0;
    end else begin
      s_cnt <= t_short ? '0 : s_cnt + 1'b1;
      if (t_short) begin
        m_cnt <= (m_cnt == MW'(MID_DIV - 1)) ? '0 : m_cnt + 1'b1;
        l_cnt <= (l_cnt == LW'(LONG_DIV - 1)) ? '0 : l_cnt + 1'b1;
      end
    end
  end

  // R3: slower ticks only coincide with a short tick
  p_mid_on_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    t_mid |-> t_short);
  p_long_on_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    t_long |-> t_short);
  // R3: short ticks are spaced by at least two cycles
  p_short_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    t_short |=> !t_short);
endmodule

// File: rtl/hitb_regfile.sv
module hitb_regfile import hitb_pkg::*; (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [7:0]                   wdata,
  output logic [7:0]                   rdata,
  output logic [NUM_REGS-1:0][7:0]     regs
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_REGS - 1);

  logic mapped;
  assign mapped = (addr <= LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= reg_reset(i);
    end else if (wr && mapped) begin
      regs[addr] <= wdata;
    end
  end

  assign rdata = mapped ? regs[addr] : 8'h00;

  // R2: a write to a mapped address lands at the next edge
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && mapped) |=> (regs[$past(addr)] == $past(wdata)));
  // R1: writes outside the map leave every setting alone
  p_unmapped_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !mapped) |=> (regs == $past(regs)));
endmodule

// File: rtl/hitb_timer.sv
module hitb_timer import hitb_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  load_t      ld,
  input  logic [3:0] ticks,
  output logic       busy,
  output logic       done
);
  logic [CNT_W-1:0] cnt;
  unit_e            unit_q;
  logic             tick_hit;

  assign tick_hit = ticks[unit_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      unit_q <= UNIT_SHORT;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt    <= ld.val;
        unit_q <= ld.unit;
        busy   <= 1'b1;
      end else if (busy && tick_hit) begin
        if (cnt <= CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R7: done only follows a running count that just ended
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R9: a (re)start never yields done on the next cycle
  p_restart_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
  // R10: without a tick or start the count and unit stay put
  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && !tick_hit) |=> (busy && $stable(cnt) && $stable(unit_q)));
endmodule

// File: rtl/handshake_timer_bank.sv
module handshake_timer_bank import hitb_pkg::*; #(
  parameter int SHORT_DIV = 8192,
  parameter int MID_DIV   = 32,
  parameter int LONG_DIV  = 600
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [7:0]            reg_wdata,
  output logic [7:0]            reg_rdata,
  input  logic                  tmr_start,
  input  logic [SEL_W-1:0]      tmr_sel,
  output logic [NUM_TIMERS-1:0] tmr_busy,
  output logic [NUM_TIMERS-1:0] tmr_done
);
  logic [NUM_REGS-1:0][7:0] regs;
  logic [3:0]               ticks;
  logic                     sel_ok;

  assign sel_ok = (tmr_sel < SEL_W'(NUM_TIMERS));

  hitb_tick_gen #(
    .SHORT_DIV(SHORT_DIV),
    .MID_DIV  (MID_DIV),
    .LONG_DIV (LONG_DIV)
  ) u_ticks (
    .clk  (clk),
    .rst_n(rst_n),
    .ticks(ticks)
  );

  hitb_regfile u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (reg_wr),
    .addr (reg_addr),
    .wdata(reg_wdata),
    .rdata(reg_rdata),
    .regs (regs)
  );

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    load_t ld;
    logic  st;
    assign ld = timer_load(t, regs);
    assign st = tmr_start && (tmr_sel == SEL_W'(t));
    hitb_timer u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .start(st),
      .ld   (ld),
      .ticks(ticks),
      .busy (tmr_busy[t]),
      .done (tmr_done[t])
    );
  end

  // R11: an out-of-range index raises no busy flag
  p_bad_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_start && !sel_ok) |=> ((tmr_busy & ~$past(tmr_busy)) == '0));
  // R7: a valid start leaves the chosen timer busy
  p_sel_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_start && sel_ok) |=> tmr_busy[$past(tmr_sel)]);
  // R7: expiry of a timer never coincides with its busy flag
  p_done_excl_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_done & tmr_busy) == '0);
endmodule

// File: tb/sim_handshake_timer_bank.sv
module sim_handshake_timer_bank;
  localparam int CLK_PERIOD = 10;
  localparam int S = 4;
  localparam int M = 3;
  localparam int L = 5;
  localparam int NT = 6;
  localparam int NR = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tmr_start = 1'b0;
  logic [2:0] tmr_sel = '0;
  logic [5:0] tmr_busy, tmr_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  handshake_timer_bank #(.SHORT_DIV(S), .MID_DIV(M), .LONG_DIV(L)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_start(tmr_start),
    .tmr_sel(tmr_sel), .tmr_busy(tmr_busy), .tmr_done(tmr_done));

  int    vectors = 0;
  int    errors  = 0;
  string cur_req = "R1";
  int    dcount [NT];

  // reference state
  logic [7:0]  mreg  [NR];
  int          mcnt  [NT];
  int          munit [NT];
  logic [5:0]  mbusy, mdone;
  int          cyc_n;

  function automatic logic [7:0] rst_val(int a);
    case (a)
      0: return 8'h03; 1: return 8'h5A; 2: return 8'h2D; 3: return 8'h3C;
      4: return 8'h09; 5: return 8'hCB; 6: return 8'h08; 7: return 8'h78;
      8: return 8'h08; default: return 8'h00;
    endcase
  endfunction

  // R4/R5/R6: expected value and unit (0 short, 1 medium, 2 long)
  function automatic int exp_val(int t);
    case (t)
      0: return (mreg[0] != 0) ? int'(mreg[0]) : int'(mreg[1]);
      1: return int'(mreg[2]);
      2: return int'(mreg[3]);
      3: return int'(mreg[4]);
      4: return int'(mreg[6]) * 256 + int'(mreg[5]);
      default: return int'(mreg[8]) * 256 + int'(mreg[7]);
    endcase
  endfunction

  function automatic int exp_unit(int t);
    if (t == 0) return (mreg[0] != 0) ? 2 : 0;
    if (t == 3) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] exp_rd(logic [3:0] a);
    return (a < NR) ? mreg[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NR; a++) mreg[a] = rst_val(a);
      for (int t = 0; t < NT; t++) begin mcnt[t] = 0; munit[t] = 0; end
      mbusy = '0; mdone = '0; cyc_n = 0;
    end else begin
      logic [2:0] tk;
      tk[0] = (cyc_n % S) == S - 1;
      tk[1] = (cyc_n % (S*M)) == S*M - 1;
      tk[2] = (cyc_n % (S*L)) == S*L - 1;
      for (int t = 0; t < NT; t++) begin
        mdone[t] = 1'b0;
        if (tmr_start && int'(tmr_sel) == t) begin
          mcnt[t] = exp_val(t); munit[t] = exp_unit(t); mbusy[t] = 1'b1;
        end else if (mbusy[t] && tk[munit[t]]) begin
          if (mcnt[t] <= 1) begin mbusy[t] = 1'b0; mdone[t] = 1'b1; end
          else mcnt[t] = mcnt[t] - 1;
        end
      end
      if (reg_wr && reg_addr < NR) mreg[reg_addr] = reg_wdata;
      cyc_n++;
    end
  end

  task automatic check_ports();
    vectors++;
    if (tmr_busy !== mbusy || tmr_done !== mdone || reg_rdata !== exp_rd(reg_addr)) begin
      errors++;
      $display("FAIL %s busy/done/rdata actual=%b/%b/%h expected=%b/%b/%h at cycle %0d",
               cur_req, tmr_busy, tmr_done, reg_rdata, mbusy, mdone,
               exp_rd(reg_addr), cyc_n);
    end
    for (int t = 0; t < NT; t++) if (tmr_done[t]) dcount[t]++;
  endtask

  task automatic cyc(input logic wr, input logic [3:0] a, input logic [7:0] d,
                     input logic st, input logic [2:0] sel);
    reg_wr = wr; reg_addr = a; reg_wdata = d; tmr_start = st; tmr_sel = sel;
    @(negedge clk);
    check_ports();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 8'h00, 1'b0, 3'd0);
  endtask

  task automatic drain(input int maxc);
    for (int i = 0; i < maxc && tmr_busy != '0; i++) cyc(1'b0, 4'd0, 8'h00, 1'b0, 3'd0);
    idle(2);
  endtask

  task automatic clr_done();
    for (int t = 0; t < NT; t++) dcount[t] = 0;
  endtask

  task automatic expect_int(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    int unsigned r;
    int n;
    r = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_ports();
    // R1: reset contents and unmapped reads
    cur_req = "R1";
    for (int a = 0; a < 16; a++) begin
      cyc(1'b0, 4'(a), 8'h00, 1'b0, 3'd0);
      expect_int("R1", "reset read", int'(reg_rdata), int'(rst_val(a)));
    end
    expect_int("R1", "reset busy", int'(tmr_busy), 0);
    cyc(1'b1, 4'd12, 8'hFF, 1'b0, 3'd0);
    expect_int("R1", "unmapped read", int'(reg_rdata), 0);
    // R2: write then read back
    cur_req = "R2";
    cyc(1'b1, 4'd2, 8'h11, 1'b0, 3'd0);
    expect_int("R2", "readback", int'(reg_rdata), 8'h11);
    // R8: zero value expires on first short tick
    cur_req = "R8";
    cyc(1'b1, 4'd2, 8'h00, 1'b0, 3'd0);
    clr_done();
    cyc(1'b0, 4'd0, 8'h00, 1'b1, 3'd1);
    n = 0;
    while (tmr_busy[1] && n < 50) begin idle(1); n++; end
    expect_int("R8", "cycles to expire", (n <= S) ? 1 : 0, 1);
    idle(2);
    expect_int("R8", "done pulses", dcount[1], 1);
    // R6: fallback to short-unit register
    cur_req = "R6";
    cyc(1'b1, 4'd0, 8'h00, 1'b0, 3'd0);
    cyc(1'b1, 4'd1, 8'h03, 1'b0, 3'd0);
    clr_done();
    cyc(1'b0, 4'd0, 8'h00, 1'b1, 3'd0);
    drain(500);
    expect_int("R6", "fallback done", dcount[0], 1);
    // R3 and R4: medium and long units
    cur_req = "R3";
    cyc(1'b1, 4'd0, 8'h02, 1'b0, 3'd0);
    cyc(1'b1, 4'd4, 8'h02, 1'b0, 3'd0);
    clr_done();
    cyc(1'b0, 4'd0, 8'h00, 1'b1, 3'd0);
    cyc(1'b0, 4'd0, 8'h00, 1'b1, 3'd3);
    drain(500);
    expect_int("R3", "long done", dcount[0], 1);
    expect_int("R4", "medium done", dcount[3], 1);
    // R5: pair weighting
    cur_req = "R5";
    cyc(1'b1, 4'd6, 8'h01, 1'b0, 3'd0);
    cyc(1'b1, 4'd5, 8'h02, 1'b0, 3'd0);
    clr_done();
    cyc(1'b0, 4'd0, 8'h00, 1'b1, 3'd4);
    n = 0;
    while (tmr_busy[4] && n < 5000) begin idle(1); n++; end
    expect_int("R5", "pair span in short ticks", (n + S - 1) / S, 258);
    // R9: restart a busy timer
    cur_req = "R9";
    cyc(1'b1, 4'd3, 8'h04, 1'b0, 3'd0);
    clr_done();
    cyc(1'b0, 4'd0, 8'h00, 1'b1, 3'd2);
    idle(9);
    cyc(1'b0, 4'd0, 8'h00, 1'b1, 3'd2);
    idle(9);
    cyc(1'b0, 4'd0, 8'h00, 1'b1, 3'd2);
    drain(200);
    expect_int("R9", "single done after restarts", dcount[2], 1);
    // R10: writes during a run
    cur_req = "R10";
    cyc(1'b1, 4'd7, 8'h03, 1'b0, 3'd0);
    cyc(1'b1, 4'd8, 8'h00, 1'b0, 3'd0);
    clr_done();
    cyc(1'b0, 4'd0, 8'h00, 1'b1, 3'd5);
    cyc(1'b1, 4'd7, 8'h60, 1'b0, 3'd0);
    n = 0;
    while (tmr_busy[5] && n < 1000) begin idle(1); n++; end
    expect_int("R10", "run unaffected", (n <= 3 * S) ? 1 : 0, 1);
    // R11: out-of-range index
    cur_req = "R11";
    cyc(1'b0, 4'd0, 8'h00, 1'b1, 3'd6);
    cyc(1'b0, 4'd0, 8'h00, 1'b1, 3'd7);
    expect_int("R11", "busy after bad index", int'(tmr_busy), 0);
    // R7: random mix
    cur_req = "R7";
    for (int i = 0; i < 4000; i++) begin
      logic wr, st;
      logic [3:0] a;
      logic [7:0] d;
      wr = ($urandom % 8) == 0;
      a  = 4'($urandom % 16);
      d  = 8'($urandom % 16);
      if (a == 4'd6 || a == 4'd8) d = d % 2;
      st = ($urandom % 8) == 0;
      cyc(wr, a, d, st, 3'($urandom % 8));
    end
    drain(20000);
    expect_int("R7", "all idle after drain", int'(tmr_busy), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule